// File: doc/BRIEF.md
# Access Permission and Protection-Key Checker

This block takes one already-translated memory access per beat and decides whether it may proceed. Each beat carries the access kind, the privilege mode, the page attributes returned by translation, the page's protection key, the 32-bit per-key rights word and three protection-control flags. The checker merges the page-permission rules with the per-key rights. It returns a registered verdict, which is either allow or fault. A fault also carries a 5-bit packed error code. The virtual address of the most recent faulting access is kept in a separate register that holds its value until the next fault.

The input and the result both use valid/ready. A beat is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the result register is empty or is being drained in the same cycle. The result appears on the output one cycle after acceptance. It stays stable while `out_ready` is low, and in that state no new beat is accepted.

Access kind encoding on `in_kind`: 2'b00 read, 2'b01 write, 2'b10 instruction fetch, 2'b11 treated as a read. `in_user_mode` is 1 for user mode and 0 for supervisor mode.

Top module: `pchk_access_checker`

## Requirements
- R1: For a data access (read or write) to a present, user page (`pg_user`=1), rights bit 2k denies every access when the page key is k, and rights bit 2k+1 denies writes only. Bits belonging to other keys have no effect.
- R2: A beat is allowed only when both the page-permission check and the key-rights check pass. Allowed results carry `out_allow`=1, `out_fault`=0 and code 0.
- R3: A write to a present page with `pg_writable`=0 faults in either privilege mode.
- R4: A user-mode access to a present page with `pg_user`=0 faults. A supervisor access to such a page is not denied by this rule.
- R5: An instruction fetch from a page with `pg_nx`=1 faults. Key rights never apply to instruction fetches.
- R6: The error code layout is: bit0 = 0 for a not-present fault and 1 for any fault on a present page; bit1 = write; bit2 = user mode; bit3 = reserved-bit violation on a present page; bit4 = instruction fetch. A present page with `pg_rsvd`=1 always faults.
- R7: When `ctl_no_sup_exec`=1, a supervisor fetch from a user page faults. When the flag is 0, that fetch is allowed.
- R8: When `ctl_no_sup_data`=1 and `ctl_sup_data_ovr`=0, a supervisor read or write to a user page faults. Setting the override allows the access, and the flag has no effect on fetches.
- R9: The result is valid one cycle after acceptance. While `out_valid`=1 and `out_ready`=0, the result holds and `in_ready`=0.
- R10: On an accepted faulting beat, `fault_addr` takes that beat's address. Allowed beats leave `fault_addr` unchanged.
- R11: After reset, `out_valid`=0 and `fault_addr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Access beat present |
| in_ready | output | 1 | Beat can be taken this cycle |
| in_vaddr | input | VA_W | Virtual address of the access |
| in_kind | input | 2 | Access kind (read/write/fetch) |
| in_user_mode | input | 1 | 1 = user mode, 0 = supervisor |
| pg_present | input | 1 | Page present |
| pg_writable | input | 1 | Page writable |
| pg_user | input | 1 | Page reachable from user mode |
| pg_nx | input | 1 | Page not executable |
| pg_rsvd | input | 1 | Reserved-bit violation seen in translation |
| pg_key | input | clog2(NUM_KEYS) | Protection key of the page |
| key_rights | input | 2*NUM_KEYS | Per-key deny-all / deny-write bits |
| ctl_no_sup_exec | input | 1 | Block supervisor fetch from user pages |
| ctl_no_sup_data | input | 1 | Block supervisor data access to user pages |
| ctl_sup_data_ovr | input | 1 | Temporarily lift the data block |
| out_valid | output | 1 | Verdict present |
| out_ready | input | 1 | Consumer takes the verdict |
| out_allow | output | 1 | Access allowed |
| out_fault | output | 1 | Access faulted |
| out_code | output | 5 | Packed fault error code |
| fault_addr | output | VA_W | Address of the last faulting access |

## Verification
The following properties are checked on every cycle: a valid result is exactly one of allow or fault, an allowed result carries a zero code, a not-present code never flags a reserved violation, the result holds under back-pressure, a result follows every accepted beat, and the fault address moves only together with a fault. The bench's directed scenarios cover the rest. These include which rights bit belongs to which key, the individual fault causes and their code bits, the supervisor-prevention flags and their override, key rights being ignored for fetches, and the fault address surviving allowed traffic.

// File: rtl/pchk_pkg.sv
package pchk_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_ALT   = 2'b11
  } acc_kind_e;

  typedef struct packed {
    logic present;
    logic writable;
    logic user;
    logic nx;
    logic rsvd;
  } page_attr_t;

  localparam int CODE_W     = 5;
  localparam int CB_PROT    = 0;
  localparam int CB_WRITE   = 1;
  localparam int CB_USER    = 2;
  localparam int CB_RSVD    = 3;
  localparam int CB_FETCH   = 4;
endpackage

// File: rtl/pchk_page_rules.sv
module pchk_page_rules
  import pchk_pkg::*;
(
  input  acc_kind_e  kind,
  input  logic       user_mode,
  input  page_attr_t attr,
  input  logic       no_sup_exec,
  input  logic       no_sup_data,
  input  logic       sup_data_ovr,
  output logic       is_write,
  output logic       is_fetch,
  output logic       absent,
  output logic       rsvd_viol,
  output logic       prot_deny
);
  logic wr_ro, usr_to_sup, exec_nx, sxp_hit, sap_hit;

  always_comb begin
    is_write   = (kind == ACC_WRITE);
    is_fetch   = (kind == ACC_FETCH);
    absent     = ~attr.present;
    rsvd_viol  = attr.present & attr.rsvd;
    wr_ro      = is_write & ~attr.writable;
    usr_to_sup = user_mode & ~attr.user;
    exec_nx    = is_fetch & attr.nx;
    sxp_hit    = ~user_mode & is_fetch & attr.user & no_sup_exec;
    sap_hit    = ~user_mode & ~is_fetch & attr.user & no_sup_data & ~sup_data_ovr;
    prot_deny  = attr.present & ~attr.rsvd &
                 (wr_ro | usr_to_sup | exec_nx | sxp_hit | sap_hit);
  end
endmodule

// File: rtl/pchk_key_rights.sv
module pchk_key_rights #(
  parameter int NUM_KEYS = 16
) (
  input  logic [2*NUM_KEYS-1:0]       rights,
  input  logic [$clog2(NUM_KEYS)-1:0] key,
  input  logic                        check_en,
  input  logic                        is_write,
  output logic                        key_deny
);
  logic [NUM_KEYS-1:0] deny_all;
  logic [NUM_KEYS-1:0] deny_wr;

  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
    assign deny_all[k] = rights[2*k];
    assign deny_wr[k]  = rights[2*k+1];
  end

  always_comb begin
    key_deny = check_en & (deny_all[key] | (is_write & deny_wr[key]));
  end
endmodule

// File: rtl/pchk_code_pack.sv
module pchk_code_pack
  import pchk_pkg::*;
(
  input  logic              absent,
  input  logic              rsvd_viol,
  input  logic              prot_deny,
  input  logic              key_deny,
  input  logic              is_write,
  input  logic              is_fetch,
  input  logic              user_mode,
  output logic              fault,
  output logic [CODE_W-1:0] code
);
  always_comb begin
    fault = absent | rsvd_viol | prot_deny | key_deny;
    code  = '0;
    if (fault) begin
      code[CB_PROT]  = ~absent;
      code[CB_WRITE] = is_write;
      code[CB_USER]  = user_mode;
      code[CB_RSVD]  = rsvd_viol;
      code[CB_FETCH] = is_fetch;
    end
  end
endmodule

// File: rtl/pchk_access_checker.sv
module pchk_access_checker
  import pchk_pkg::*;
#(
  parameter int VA_W     = 48,
  parameter int NUM_KEYS = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [VA_W-1:0]             in_vaddr,
  input  logic [1:0]                  in_kind,
  input  logic                        in_user_mode,
  input  logic                        pg_present,
  input  logic                        pg_writable,
  input  logic                        pg_user,
  input  logic                        pg_nx,
  input  logic                        pg_rsvd,
  input  logic [$clog2(NUM_KEYS)-1:0] pg_key,
  input  logic [2*NUM_KEYS-1:0]       key_rights,
  input  logic                        ctl_no_sup_exec,
  input  logic                        ctl_no_sup_data,
  input  logic                        ctl_sup_data_ovr,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic                        out_allow,
  output logic                        out_fault,
  output logic [4:0]                  out_code,
  output logic [VA_W-1:0]             fault_addr
);
  page_attr_t        attr;
  logic              is_write, is_fetch, absent, rsvd_viol, prot_deny, key_deny;
  logic              fault_w;
  logic [CODE_W-1:0] code_w;
  logic              accept;

  assign attr = '{present: pg_present, writable: pg_writable, user: pg_user,
                  nx: pg_nx, rsvd: pg_rsvd};

  pchk_page_rules u_rules (
    .kind         (acc_kind_e'(in_kind)),
    .user_mode    (in_user_mode),
    .attr         (attr),
    .no_sup_exec  (ctl_no_sup_exec),
    .no_sup_data  (ctl_no_sup_data),
    .sup_data_ovr (ctl_sup_data_ovr),
    .is_write     (is_write),
    .is_fetch     (is_fetch),
    .absent       (absent),
    .rsvd_viol    (rsvd_viol),
    .prot_deny    (prot_deny)
  );

  pchk_key_rights #(.NUM_KEYS(NUM_KEYS)) u_keys (
    .rights   (key_rights),
    .key      (pg_key),
    .check_en (pg_present & pg_user & ~is_fetch),
    .is_write (is_write),
    .key_deny (key_deny)
  );

  pchk_code_pack u_code (
    .absent    (absent),
    .rsvd_viol (rsvd_viol),
    .prot_deny (prot_deny),
    .key_deny  (key_deny),
    .is_write  (is_write),
    .is_fetch  (is_fetch),
    .user_mode (in_user_mode),
    .fault     (fault_w),
    .code      (code_w)
  );

  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_allow  <= 1'b0;
      out_fault  <= 1'b0;
      out_code   <= '0;
      fault_addr <= '0;
    end else begin
      if (accept) begin
        out_valid <= 1'b1;
        out_allow <= ~fault_w;
        out_fault <= fault_w;
        out_code  <= code_w;
        if (fault_w) fault_addr <= in_vaddr;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R9: a verdict is exactly one of allow / fault
  p_onehot_verdict_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot({out_allow, out_fault}));

  // R9: verdict follows every accepted beat
  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R9: stalled verdict holds
  p_hold_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_code) && $stable(out_allow)));

  // R2: allowed result has an empty code
  p_allow_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_allow) |-> (out_code == '0));

  // R6: not-present code never flags a reserved violation
  p_absent_no_rsvd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fault && !out_code[CB_PROT]) |-> !out_code[CB_RSVD]);

  // R10: fault address moves only with a fresh fault
  p_faddr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fault_addr) |-> (out_valid && out_fault));
endmodule

// File: tb/pchk_access_checker_tb_top.sv
module pchk_access_checker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int VA_W = 48;
  localparam int NK   = 16;
  localparam int WATCHDOG = 20000;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [VA_W-1:0] in_vaddr = '0;
  logic [1:0]      in_kind = 2'b00;
  logic            in_user_mode = 1'b1;
  logic            pg_present = 1'b1, pg_writable = 1'b1, pg_user = 1'b1;
  logic            pg_nx = 1'b0, pg_rsvd = 1'b0;
  logic [3:0]      pg_key = '0;
  logic [2*NK-1:0] key_rights = '0;
  logic            ctl_no_sup_exec = 1'b0, ctl_no_sup_data = 1'b0, ctl_sup_data_ovr = 1'b0;
  logic            out_valid;
  logic            out_ready = 1'b1;
  logic            out_allow, out_fault;
  logic [4:0]      out_code;
  logic [VA_W-1:0] fault_addr;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pchk_access_checker #(.VA_W(VA_W), .NUM_KEYS(NK)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_vaddr(in_vaddr), .in_kind(in_kind), .in_user_mode(in_user_mode),
    .pg_present(pg_present), .pg_writable(pg_writable), .pg_user(pg_user),
    .pg_nx(pg_nx), .pg_rsvd(pg_rsvd), .pg_key(pg_key), .key_rights(key_rights),
    .ctl_no_sup_exec(ctl_no_sup_exec), .ctl_no_sup_data(ctl_no_sup_data),
    .ctl_sup_data_ovr(ctl_sup_data_ovr), .out_valid(out_valid), .out_ready(out_ready),
    .out_allow(out_allow), .out_fault(out_fault), .out_code(out_code),
    .fault_addr(fault_addr)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic defaults();
    in_kind = 2'b00; in_user_mode = 1'b1;
    pg_present = 1'b1; pg_writable = 1'b1; pg_user = 1'b1; pg_nx = 1'b0; pg_rsvd = 1'b0;
    pg_key = '0; key_rights = '0;
    ctl_no_sup_exec = 1'b0; ctl_no_sup_data = 1'b0; ctl_sup_data_ovr = 1'b0;
  endtask

  // Issue one beat with out_ready high; verdict checked one cycle later.
  task automatic issue(string tag, logic ef, logic [4:0] ec);
    @(negedge clk);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"}, 64'(out_valid), 64'd1);
    check({tag, " fault"}, 64'(out_fault), 64'(ef));
    check({tag, " allow"}, 64'(out_allow), 64'(!ef));
    check({tag, " code"},  64'(out_code),  64'(ec));
    if (ef) check({tag, " addr"}, 64'(fault_addr), 64'(in_vaddr));
  endtask

  task automatic t_reset();
    check("R11 out_valid after reset", 64'(out_valid), 64'd0);
    check("R11 fault_addr after reset", 64'(fault_addr), 64'd0);
    check("R9 in_ready after reset", 64'(in_ready), 64'd1);
  endtask

  task automatic t_key_rights();
    defaults(); in_vaddr = 48'h1000; pg_key = 4'd5;
    key_rights = 32'h1 << 10;
    issue("R1 key5 deny-all read", 1'b1, 5'b00101);
    key_rights = 32'h1 << 11;
    issue("R1 key5 deny-write read ok", 1'b0, 5'b00000);
    in_kind = 2'b01;
    issue("R1 key5 deny-write on write", 1'b1, 5'b00111);
    in_kind = 2'b00; key_rights = 32'h3 << 12;
    issue("R1 other key bits ignored", 1'b0, 5'b00000);
    pg_key = 4'd15; key_rights = 32'h1 << 30;
    issue("R1 key15 deny-all", 1'b1, 5'b00101);
    in_user_mode = 1'b0; pg_key = 4'd2; key_rights = 32'h1 << 4;
    issue("R1 key applies in supervisor", 1'b1, 5'b00001);
  endtask

  task automatic t_both();
    defaults(); in_vaddr = 48'h2000; in_kind = 2'b01;
    issue("R2 page and key allow", 1'b0, 5'b00000);
    key_rights = 32'h2;
    issue("R2 key denies writable page", 1'b1, 5'b00111);
    pg_user = 1'b0; in_user_mode = 1'b0;
    issue("R2 key ignored on supervisor page", 1'b0, 5'b00000);
  endtask

  task automatic t_write_ro();
    defaults(); in_vaddr = 48'h3000; in_kind = 2'b01; pg_writable = 1'b0;
    issue("R3 user write to read-only", 1'b1, 5'b00111);
    in_user_mode = 1'b0; pg_user = 1'b0;
    issue("R3 supervisor write to read-only", 1'b1, 5'b00011);
    in_kind = 2'b00;
    issue("R3 read of read-only allowed", 1'b0, 5'b00000);
  endtask

  task automatic t_user_mode();
    defaults(); in_vaddr = 48'h4000; pg_user = 1'b0;
    issue("R4 user read of supervisor page", 1'b1, 5'b00101);
    in_user_mode = 1'b0;
    issue("R4 supervisor read of supervisor page", 1'b0, 5'b00000);
  endtask

  task automatic t_nx();
    defaults(); in_vaddr = 48'h5000; in_kind = 2'b10; pg_nx = 1'b1;
    issue("R5 fetch from no-exec", 1'b1, 5'b10101);
    pg_nx = 1'b0; key_rights = '1;
    issue("R5 fetch ignores key rights", 1'b0, 5'b00000);
    in_kind = 2'b11; key_rights = '0; pg_writable = 1'b0;
    issue("R5 kind 3 treated as read", 1'b0, 5'b00000);
  endtask

  task automatic t_absent_rsvd();
    defaults(); in_vaddr = 48'h6000; pg_present = 1'b0; in_kind = 2'b01;
    issue("R6 not-present user write", 1'b1, 5'b00110);
    in_kind = 2'b00; in_user_mode = 1'b0;
    issue("R6 not-present supervisor read", 1'b1, 5'b00000);
    pg_present = 1'b1; pg_rsvd = 1'b1; in_user_mode = 1'b1;
    issue("R6 reserved violation", 1'b1, 5'b01101);
    in_kind = 2'b10;
    issue("R6 reserved violation on fetch", 1'b1, 5'b11101);
  endtask

  task automatic t_sxp();
    defaults(); in_vaddr = 48'h7000; in_kind = 2'b10; in_user_mode = 1'b0;
    ctl_no_sup_exec = 1'b1;
    issue("R7 supervisor fetch of user page blocked", 1'b1, 5'b10001);
    ctl_no_sup_exec = 1'b0;
    issue("R7 allowed when disabled", 1'b0, 5'b00000);
  endtask

  task automatic t_sap();
    defaults(); in_vaddr = 48'h8000; in_user_mode = 1'b0; ctl_no_sup_data = 1'b1;
    issue("R8 supervisor read of user page blocked", 1'b1, 5'b00001);
    in_kind = 2'b01;
    issue("R8 supervisor write of user page blocked", 1'b1, 5'b00011);
    ctl_sup_data_ovr = 1'b1;
    issue("R8 override allows", 1'b0, 5'b00000);
    ctl_sup_data_ovr = 1'b0; in_kind = 2'b10;
    issue("R8 no effect on fetch", 1'b0, 5'b00000);
  endtask

  task automatic t_backpressure();
    defaults(); in_vaddr = 48'h9000; pg_user = 1'b0;   // A: faulting user read
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R9 A valid", 64'(out_valid), 64'd1);
    check("R9 A faults", 64'(out_fault), 64'd1);
    check("R9 in_ready low when stalled", 64'(in_ready), 64'd0);
    pg_user = 1'b1; in_vaddr = 48'hA000;                // B: allowed
    @(posedge clk);
    @(negedge clk);
    check("R9 A held under stall", 64'(out_code), 64'h05);
    check("R9 A still faulting", 64'(out_fault), 64'd1);
    check("R10 addr unchanged by stalled B", 64'(fault_addr), 64'h9000);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 B taken on drain", 64'(out_allow), 64'd1);
    @(posedge clk);
    @(negedge clk);
    check("R9 empties when drained", 64'(out_valid), 64'd0);
  endtask

  task automatic t_fault_addr();
    defaults(); in_vaddr = 48'hBEEF_0000_1234; pg_present = 1'b0;
    issue("R10 fault latches address", 1'b1, 5'b00100);
    defaults(); in_vaddr = 48'h0000_0000_5678;
    issue("R10 allowed beat", 1'b0, 5'b00000);
    check("R10 address held after allow", 64'(fault_addr), 64'hBEEF_0000_1234);
    in_vaddr = 48'h0000_1111_2222; pg_rsvd = 1'b1;
    issue("R10 next fault replaces address", 1'b1, 5'b01101);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_key_rights();
    t_both();
    t_write_ro();
    t_user_mode();
    t_nx();
    t_absent_rsvd();
    t_sxp();
    t_sap();
    t_backpressure();
    t_fault_addr();
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end
endmodule